// File: doc/BRIEF.md
# Single-Channel Block-Transfer DMA Engine

This block moves a block of words between a peripheral and memory so that the processor does not have to copy each word itself. Software sets up three registers: the first memory address, the number of words, and a control/status word. The control/status word picks the direction, picks the bus mode and enables the interrupt. A write with the go bit set starts the block. The engine then waits for the peripheral to say it is ready and asks for the shared bus. Once the bus is granted, it drives one address and command per word. After each word it steps the address and lowers the remaining count.

There are two bus modes. In cycle-stealing mode the engine gives the bus back after every word and asks for it again for the next one, so processor cycles fit in between. In burst mode it keeps the bus and issues words back to back until the block ends. When the count runs out, or the memory side answers a word with an error, the engine marks the block finished. It raises an interrupt only if software enabled one.

A small registered arbiter inside the block shares the bus between the engine and the processor, and always favours the engine.

Top module: `dma_block_channel`

## Requirements
- R1: After reset, `irq`, `mem_valid` and `cpu_gnt` are 0, and the control/status word reads 0x0000_0000.
- R2: Register selects are 0 = address, 1 = count, 2 = control/status. The control/status bits are: bit 0 finished, bit 1 direction (1 = memory write), bit 2 go (write-only, reads 0), bit 3 burst, bit 4 error, bit 30 interrupt pending, bit 31 interrupt enable. Writes to the address or count register while a block is active are ignored.
- R3: After go with a non-zero count, no bus cycle (`mem_valid`) appears until `dev_ready` is 1. `mem_valid` is only ever high while the engine holds the grant and `cpu_gnt` is 0.
- R4: Each word uses the current address, and `mem_we` equals the direction bit. Each completed word adds 4 to the address and subtracts 1 from the count.
- R5: The bus grant is registered. When the engine and the processor request in the same cycle, the engine wins. The processor is granted whenever the engine is not requesting. The two grants are never both high.
- R6: In cycle-stealing mode `mem_valid` goes low after every completed word, so an N-word block shows N separate bus cycles.
- R7: In burst mode `mem_valid` stays high from the first word to the last, and the address moves on by 4 on the cycle after each acknowledge.
- R8: When the last word completes, the finished bit is set, the count reads 0 and the address reads start + 4·N.
- R9: `irq` is high only while both the finished bit and interrupt enable are 1. A block that ends with interrupt enable at 0 raises no interrupt.
- R10: Reading the control/status word, or writing it with bit 0 set, clears the pending interrupt. Go clears finished, error and pending interrupt.
- R11: Go with a count of 0 sets the finished bit on the next clock (and the pending interrupt if enabled) and produces no bus cycle.
- R12: A word answered with `mem_err` ends the block at once. The error and finished bits are set, and the interrupt follows R9. The failed word does not advance the address or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (a read of select 2 clears the pending interrupt) |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` |
| dev_ready | input | 1 | Peripheral ready for the next word |
| cpu_req | input | 1 | Processor bus request |
| cpu_gnt | output | 1 | Processor bus grant |
| mem_valid | output | 1 | Engine bus cycle active |
| mem_we | output | 1 | Bus cycle is a memory write |
| mem_addr | output | AW (32) | Bus cycle address |
| mem_ack | input | 1 | Word completed |
| mem_err | input | 1 | Word answered with an error |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A bus cycle always has the grant and the processor is locked out while it does. The grants never overlap, and a tie always goes to the engine. In cycle-stealing mode the bus drops after each acknowledged word. In burst mode the address steps by 4 with the bus still held. An error or a zero count never leaves a bus cycle behind. The interrupt never shows without finished and enable. Other behaviours need the bench's scenarios, checked against its reference model: the number of separate bus cycles per block, the final address and count readback, holding off until the peripheral is ready, the clear-on-read and clear-on-write of the interrupt, and the registers that ignore writes mid-block.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_MOVE = 2'd3
  } eng_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int BIT_DONE  = 0;
  localparam int BIT_DIR   = 1;
  localparam int BIT_GO    = 2;
  localparam int BIT_BURST = 3;
  localparam int BIT_ERR   = 4;
  localparam int BIT_IRQ   = 30;
  localparam int BIT_IE    = 31;
endpackage

// File: rtl/dma_ch_arbiter.sv
module dma_ch_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic cpu_req,
  output logic dma_gnt,
  output logic cpu_gnt
);
  logic dma_gnt_d, cpu_gnt_d;

  always_comb begin
    dma_gnt_d = dma_req;
    cpu_gnt_d = cpu_req && !dma_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_gnt <= 1'b0;
      cpu_gnt <= 1'b0;
    end else begin
      dma_gnt <= dma_gnt_d;
      cpu_gnt <= cpu_gnt_d;
    end
  end
endmodule

// File: rtl/dma_ch_engine.sv
module dma_ch_engine
  import dma_ch_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          start,
  input  logic          burst,
  input  logic          dev_ready,
  input  logic          gnt,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          busy,
  output logic          req,
  output logic          mem_valid,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          fin,
  output logic          fin_err
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);
  localparam logic [CW-1:0] ONE  = CW'(1);

  eng_state_t    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          addr_en, cnt_en;
  logic          done_word;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    addr_en   = 1'b0;
    cnt_en    = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    done_word = (state_q == ST_MOVE) && (mem_ack || mem_err);
    unique case (state_q)
      ST_IDLE: begin
        if (ld_addr) begin
          addr_d  = addr_in;
          addr_en = 1'b1;
        end
        if (ld_cnt) begin
          cnt_d  = cnt_in;
          cnt_en = 1'b1;
        end
        if (start) begin
          if (cnt_q == '0) fin = 1'b1;
          else             state_d = ST_WAIT;
        end
      end
      ST_WAIT: if (dev_ready) state_d = ST_REQ;
      ST_REQ:  if (gnt) state_d = ST_MOVE;
      ST_MOVE: begin
        if (done_word) begin
          if (mem_err) begin
            fin     = 1'b1;
            fin_err = 1'b1;
            state_d = ST_IDLE;
          end else begin
            addr_d  = addr_q + STEP;
            cnt_d   = cnt_q - ONE;
            addr_en = 1'b1;
            cnt_en  = 1'b1;
            if (cnt_q == ONE) begin
              fin     = 1'b1;
              state_d = ST_IDLE;
            end else if (!burst) begin
              state_d = ST_WAIT;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign req       = (state_q == ST_REQ) || (state_q == ST_MOVE);
  assign mem_valid = (state_q == ST_MOVE);
  assign addr_o    = addr_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/dma_ch_csr.sv
module dma_ch_csr
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          busy,
  input  logic          fin,
  input  logic          fin_err,
  input  logic [AW-1:0] addr_val,
  input  logic [CW-1:0] cnt_val,
  output logic [31:0]   cfg_rdata,
  output logic          start,
  output logic          ld_addr,
  output logic          ld_cnt,
  output logic          dir,
  output logic          burst,
  output logic          ie,
  output logic          done,
  output logic          irq
);
  logic wr_ctrl, mode_en, irq_clr;
  logic ie_d, done_d, err_d, irq_d;
  logic err_q, irq_q;
  logic unused_wbits;

  assign unused_wbits = ^{cfg_wdata[29:5], cfg_wdata[30]};

  always_comb begin
    wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
    mode_en = wr_ctrl && !busy;
    start   = mode_en && cfg_wdata[BIT_GO];
    ld_addr = cfg_wr && (cfg_sel == SEL_ADDR) && !busy;
    ld_cnt  = cfg_wr && (cfg_sel == SEL_CNT) && !busy;
    ie_d    = wr_ctrl ? cfg_wdata[BIT_IE] : ie;
    irq_clr = start || (cfg_rd && (cfg_sel == SEL_CTRL))
           || (wr_ctrl && cfg_wdata[BIT_DONE]);
    done_d  = fin ? 1'b1 : (start ? 1'b0 : done);
    err_d   = fin_err ? 1'b1 : (start ? 1'b0 : err_q);
    irq_d   = fin ? ie_d : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir   <= 1'b0;
      burst <= 1'b0;
    end else if (mode_en) begin
      dir   <= cfg_wdata[BIT_DIR];
      burst <= cfg_wdata[BIT_BURST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      done  <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie    <= ie_d;
      done  <= done_d;
      err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q && ie && done;

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_sel)
      SEL_ADDR: cfg_rdata = 32'(addr_val);
      SEL_CNT:  cfg_rdata = 32'(cnt_val);
      SEL_CTRL: begin
        cfg_rdata[BIT_IE]    = ie;
        cfg_rdata[BIT_IRQ]   = irq;
        cfg_rdata[BIT_ERR]   = err_q;
        cfg_rdata[BIT_BURST] = burst;
        cfg_rdata[BIT_DIR]   = dir;
        cfg_rdata[BIT_DONE]  = done;
      end
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel #(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          dev_ready,
  input  logic          cpu_req,
  output logic          cpu_gnt,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq
);
  logic          start, ld_addr, ld_cnt, dir, burst, ie, done;
  logic          busy, dma_req, dma_gnt, fin, fin_err;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;

  dma_ch_csr #(.AW(AW), .CW(CW)) u_csr (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .busy(busy), .fin(fin),
    .fin_err(fin_err), .addr_val(cur_addr), .cnt_val(cur_cnt),
    .cfg_rdata(cfg_rdata), .start(start), .ld_addr(ld_addr),
    .ld_cnt(ld_cnt), .dir(dir), .burst(burst), .ie(ie), .done(done),
    .irq(irq)
  );

  dma_ch_engine #(.AW(AW), .CW(CW), .STRIDE(STRIDE)) u_eng (
    .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .addr_in(cfg_wdata[AW-1:0]), .cnt_in(cfg_wdata[CW-1:0]),
    .start(start), .burst(burst), .dev_ready(dev_ready), .gnt(dma_gnt),
    .mem_ack(mem_ack), .mem_err(mem_err), .busy(busy), .req(dma_req),
    .mem_valid(mem_valid), .addr_o(cur_addr), .cnt_o(cur_cnt),
    .fin(fin), .fin_err(fin_err)
  );

  dma_ch_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .cpu_req(cpu_req),
    .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt)
  );

  assign mem_addr = cur_addr;
  assign mem_we   = mem_valid && dir;
endmodule

// File: rtl/dma_ch_checker.sv
module dma_ch_checker #(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int STRIDE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ack,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic          cpu_req,
  input logic          cpu_gnt,
  input logic          dma_req,
  input logic          dma_gnt,
  input logic          burst,
  input logic [CW-1:0] cur_cnt,
  input logic          start,
  input logic          irq,
  input logic          done,
  input logic          ie
);
  AST_VALID_HAS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (dma_gnt && !cpu_gnt)); // R3
  AST_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && cpu_req) |=> !cpu_gnt); // R5
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_gnt && cpu_gnt)); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ack && !mem_err && burst && cur_cnt > CW'(1))
    |=> (mem_valid && mem_addr == $past(mem_addr) + AW'(STRIDE))); // R7
  AST_STEAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && (mem_ack || mem_err) && !burst) |=> !mem_valid); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && ie)); // R9
  AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cur_cnt == '0) |=> !mem_valid); // R11
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_err) |=> !mem_valid); // R12
endmodule

bind dma_block_channel dma_ch_checker #(.AW(AW), .CW(CW), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ack(mem_ack),
  .mem_err(mem_err), .mem_addr(mem_addr), .cpu_req(cpu_req),
  .cpu_gnt(cpu_gnt), .dma_req(dma_req), .dma_gnt(dma_gnt), .burst(burst),
  .cur_cnt(cur_cnt), .start(start), .irq(irq), .done(done), .ie(ie)
);

// File: tb/sim_dma_block_channel.sv
module sim_dma_block_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd, dev_ready, cpu_req, mem_ack, mem_err;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr;
  logic        cpu_gnt, mem_valid, mem_we, irq;

  always #10 clk = ~clk;

  dma_block_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dev_ready(dev_ready), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  int  m_addr = 0, m_cnt = 0, m_widx = 0;
  bit  m_busy = 0, m_done = 0, m_err = 0, m_irq = 0, m_ie = 0, m_dir = 0, m_burst = 0;
  int  lat = 0, err_at = -1, wc = 0;
  int  fires = 0, rises = 0;
  bit  prev_valid = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison and model advance, mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == (m_irq && m_ie && m_done), "R9 irq vs model", irq, m_irq && m_ie && m_done);
      if (mem_valid) begin
        chk(m_busy, "R3 bus cycle while model idle", mem_valid, 0);
        chk(mem_addr == m_addr[31:0], "R4 address", mem_addr, m_addr);
        chk(mem_we == m_dir, "R4 direction", mem_we, m_dir);
        chk(!cpu_gnt, "R5 cpu locked out", cpu_gnt, 0);
      end
      if (mem_valid && !prev_valid) rises++;
      prev_valid = mem_valid;
      // responder for the coming edge
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (mem_valid) begin
        if (wc >= lat) begin
          if (m_widx == err_at) mem_err = 1'b1;
          else                  mem_ack = 1'b1;
          wc = 0;
        end else wc++;
      end else wc = 0;
      // register-side effects of the coming edge
      if (cfg_rd && cfg_sel == 2'd2) m_irq = 0;
      if (cfg_wr && cfg_sel == 2'd0 && !m_busy) m_addr = cfg_wdata;
      if (cfg_wr && cfg_sel == 2'd1 && !m_busy) m_cnt = cfg_wdata[15:0];
      if (cfg_wr && cfg_sel == 2'd2) begin
        m_ie = cfg_wdata[31];
        if (cfg_wdata[0]) m_irq = 0;
        if (!m_busy) begin
          m_dir = cfg_wdata[1];
          m_burst = cfg_wdata[3];
          if (cfg_wdata[2]) begin
            m_done = 0; m_err = 0; m_irq = 0; m_widx = 0;
            if (m_cnt == 0) begin m_done = 1; m_irq = m_ie; end
            else m_busy = 1;
          end
        end
      end
      if (mem_valid && (mem_ack || mem_err)) begin
        fires++;
        if (mem_err) begin
          m_done = 1; m_err = 1; m_irq = m_ie; m_busy = 0;
        end else begin
          m_addr += 4; m_cnt--; m_widx++;
          if (m_cnt == 0) begin m_done = 1; m_irq = m_ie; m_busy = 0; end
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
    @(posedge clk); #2;
    cfg_rd = 1'b1; cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
    @(posedge clk); #2;
    cfg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_sel = 0; cfg_wdata = 0;
    dev_ready = 0; cpu_req = 0; mem_ack = 0; mem_err = 0;
    repeat (5) @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(mem_valid == 0, "R1 mem_valid after reset", mem_valid, 0);
    chk(cpu_gnt == 0, "R1 cpu_gnt after reset", cpu_gnt, 0);
    cfg_read(2'd2, rd);
    chk(rd == 32'h0, "R1 status after reset", rd, 0);

    // R2 register readback
    cfg_write(2'd0, 32'h0000_1000);
    cfg_write(2'd1, 32'd3);
    cfg_read(2'd0, rd); chk(rd == 32'h1000, "R2 address readback", rd, 32'h1000);
    cfg_read(2'd1, rd); chk(rd == 32'd3, "R2 count readback", rd, 3);

    // cycle stealing, memory read, interrupt enabled, processor contending
    cpu_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(cpu_gnt == 1, "R5 cpu granted when engine idle", cpu_gnt, 1);
    fires = 0; rises = 0;
    cfg_write(2'd2, 32'h8000_0004);
    repeat (6) @(negedge clk);
    chk(rises == 0, "R3 no bus cycle before dev_ready", rises, 0);
    chk(cpu_gnt == 1, "R5 cpu keeps bus while engine waits", cpu_gnt, 1);
    dev_ready = 1'b1;
    wait_idle();
    chk(fires == 3, "R4 three words moved", fires, 3);
    chk(rises == 3, "R6 separate bus cycle per word", rises, 3);
    chk(irq == 1, "R9 irq after enabled completion", irq, 1);
    cfg_read(2'd1, rd); chk(rd == 0, "R8 count at end", rd, 0);
    cfg_read(2'd0, rd); chk(rd == 32'h100C, "R8 address at end", rd, 32'h100C);
    cfg_read(2'd2, rd); chk(rd == 32'hC000_0001, "R8 status finished", rd, 32'hC000_0001);
    @(negedge clk);
    chk(irq == 0, "R10 read clears irq", irq, 0);

    // burst, memory write, interrupt disabled, slow responder
    lat = 1;
    cfg_write(2'd0, 32'h0000_2000);
    cfg_write(2'd1, 32'd4);
    fires = 0; rises = 0;
    cfg_write(2'd2, 32'h0000_000E);
    wait_idle();
    chk(fires == 4, "R7 four burst words", fires, 4);
    chk(rises == 1, "R7 bus held for whole burst", rises, 1);
    chk(irq == 0, "R9 no irq with enable clear", irq, 0);
    cfg_read(2'd0, rd); chk(rd == 32'h2010, "R8 burst end address", rd, 32'h2010);
    cfg_read(2'd2, rd); chk(rd == 32'h0000_000B, "R2 status fields", rd, 32'h0000_000B);

    // zero count
    lat = 0;
    cfg_write(2'd1, 32'd0);
    rises = 0;
    cfg_write(2'd2, 32'h8000_0004);
    repeat (3) @(negedge clk);
    chk(rises == 0, "R11 no bus cycle for zero count", rises, 0);
    chk(irq == 1, "R11 zero count finishes with irq", irq, 1);
    cfg_write(2'd2, 32'h8000_0001);
    @(negedge clk);
    chk(irq == 0, "R10 write done bit clears irq", irq, 0);
    cfg_read(2'd2, rd); chk(rd == 32'h8000_0001, "R11 finished kept", rd, 32'h8000_0001);

    // error mid-burst
    err_at = 2;
    cfg_write(2'd0, 32'h0000_3000);
    cfg_write(2'd1, 32'd5);
    fires = 0;
    cfg_write(2'd2, 32'h8000_000C);
    wait_idle();
    chk(fires == 3, "R12 block stopped at failing word", fires, 3);
    chk(irq == 1, "R12 irq on error completion", irq, 1);
    cfg_read(2'd1, rd); chk(rd == 3, "R12 remaining count", rd, 3);
    cfg_read(2'd0, rd); chk(rd == 32'h3008, "R12 address not advanced", rd, 32'h3008);
    cfg_read(2'd2, rd); chk(rd == 32'hC000_0019, "R12 error status", rd, 32'hC000_0019);

    // restart holds for the peripheral; writes while busy ignored
    err_at = -1;
    dev_ready = 1'b0;
    cfg_write(2'd2, 32'h8000_0004);
    cfg_read(2'd2, rd); chk(rd == 32'h8000_0000, "R10 go clears finished and error", rd, 32'h8000_0000);
    cfg_write(2'd1, 32'd7);
    cfg_write(2'd0, 32'h0000_0000);
    cfg_read(2'd1, rd); chk(rd == 3, "R2 count write ignored while busy", rd, 3);
    cfg_read(2'd0, rd); chk(rd == 32'h3008, "R2 address write ignored while busy", rd, 32'h3008);
    fires = 0;
    dev_ready = 1'b1;
    wait_idle();
    chk(fires == 3, "R6 resumed block words", fires, 3);
    cfg_read(2'd0, rd); chk(rd == 32'h3014, "R8 resumed end address", rd, 32'h3014);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule